// File: doc/BRIEF.md
# Hash Message Input Sequencer

This block sits in front of a 512-bit-block hash compression core. It takes the message as a stream of 32-bit words, either from a processor write port or from a DMA port that marks the final word. It collects sixteen words into a block and hands each finished block to the core over a valid/ready handshake. A block is only released once the first word of the following block has arrived. Until then the sixteenth word waits in a one-word holding register in front of the sixteen-word store, so that the block that is known to be last can still receive padding.

When the message ends, the block builds the final block or blocks. It masks the last word down to its valid bits and places a single one bit right after them. It then fills with zeros and writes the 64-bit message length into the last two words. If the space left after the message is too small for the one bit and the length, it emits a second padding block. A message ends either through a final command pulse or through the DMA last flag. A new message is started with an init pulse, which clears the stored words and the running bit count.

Top module: `hash_msg_sequencer`

## Requirements
- R1: After reset, in_ready_o is 1 and busy_o, err_o and blk_valid_o are 0.
- R2: A block of 16 words is presented on blk_data_o only when a 17th word is written. Message word k of the block sits at bits [32k+31:32k], and message bit 0 is bit 0 of the first word.
- R3: From the write that releases a full block until the core accepts it, in_ready_o is 0 and further data writes are dropped without error.
- R4: While blk_valid_o is 1 and blk_ready_i is 0, blk_valid_o stays 1 and blk_data_o is unchanged.
- R5: A final_i pulse pads the message. last_bits_i gives the valid bits of the last word (1 to 31 as is, 0 meaning 32). Bits above the valid count are cleared and a one bit follows the last valid bit. Word 14 of the last block holds the low 32 bits of the message bit length and word 15 holds the high 32 bits.
- R6: If fewer than 65 bits remain in the block after the last message bit, an extra block is emitted that carries the length. It also carries the one bit when the message exactly filled the previous block.
- R7: A DMA word written with dma_last_i set is taken as data and then ends the message exactly as a final_i pulse would, with last_bits_i sampled alongside it.
- R8: busy_o is 1 from the end-of-message request until the core accepts the last padded block. Data writes while busy_o is 1 are dropped, and err_o pulses for one cycle after each one.
- R9: init_i discards all buffered words and restarts the bit length at zero.
- R10: An empty message (init, then final with no data) yields one block whose word 0 is 1 and whose other words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_i | input | 1 | Start of a new message, clears buffer and length |
| cpu_wr_i | input | 1 | Processor data word write strobe |
| cpu_wdata_i | input | 32 | Processor data word |
| dma_valid_i | input | 1 | DMA data word strobe (wins over the processor port) |
| dma_wdata_i | input | 32 | DMA data word |
| dma_last_i | input | 1 | Marks the DMA word as the last word of the message |
| final_i | input | 1 | End-of-message command pulse |
| last_bits_i | input | 5 | Valid bits in the last word, 0 encodes 32 |
| in_ready_o | output | 1 | A data word may be written |
| busy_o | output | 1 | Final padding in progress |
| err_o | output | 1 | One-cycle pulse after a dropped write while busy |
| blk_valid_o | output | 1 | Block available for the digest core |
| blk_data_o | output | 512 | Block, word k at bits [32k+31:32k] |
| blk_ready_i | input | 1 | Digest core accepts the block |

## Verification
The hardest case to reach from the ports is a message that fills the first block to within 64 bits or less of its end. Only there does the extra length block appear, and the one bit can land in word 14 of the first block or at bit 0 of the second. The stimulus table therefore sweeps message lengths across the 447/448 and 512 bit boundaries and past one and two released data blocks. Each block is compared with a padded image the bench builds bit by bit from the message length. A held-off core is used to reach the stalled-block and busy-write cases.

// File: rtl/hash_seq_pkg.sv
// Shared sizing and state encoding for the hash message input sequencer.
// Assumes a length field of exactly two data words.
package hash_seq_pkg;
    localparam int WORD_W    = 32;
    localparam int BLK_WORDS = 16;
    localparam int LEN_W     = 64;
    localparam int BLK_W     = WORD_W * BLK_WORDS;
    localparam int CNT_W     = $clog2(BLK_WORDS + 1);
    localparam int NB_W      = $clog2(WORD_W);

    typedef enum logic [1:0] {
        ST_FILL = 2'd0,
        ST_FULL = 2'd1,
        ST_PAD1 = 2'd2,
        ST_PAD2 = 2'd3
    } seq_state_t;
endpackage

// File: rtl/hash_word_buffer.sv
// Word store for one block plus a one-word holding register in front of it.
// Each accepted word moves the previous holding word into the store, so the
// store only becomes full when the word after the block has arrived.
// Assumes the controller never pushes into a full store.
module hash_word_buffer #(
    parameter int WORD_W    = hash_seq_pkg::WORD_W,
    parameter int BLK_WORDS = hash_seq_pkg::BLK_WORDS,
    localparam int BLK_W    = WORD_W * BLK_WORDS,
    localparam int CNT_W    = $clog2(BLK_WORDS + 1),
    localparam int IDX_W    = $clog2(BLK_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              push_i,
    input  logic [WORD_W-1:0] push_data_i,
    input  logic              release_i,
    input  logic              load_i,
    input  logic [BLK_W-1:0]  load_blk_i,
    output logic [BLK_W-1:0]  blk_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [WORD_W-1:0] hold_o,
    output logic              hold_v_o
);
    logic [WORD_W-1:0] store_q [BLK_WORDS];
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] hold_q;
    logic              hold_v_q;

    // Store, holding register and fill count update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q    <= '0;
            hold_q   <= '0;
            hold_v_q <= 1'b0;
            for (int k = 0; k < BLK_WORDS; k++) store_q[k] <= '0;
        end else if (load_i) begin
            for (int k = 0; k < BLK_WORDS; k++)
                store_q[k] <= load_blk_i[k*WORD_W +: WORD_W];
        end else if (release_i) begin
            cnt_q <= '0;
        end else if (push_i) begin
            if (hold_v_q) begin
                store_q[cnt_q[IDX_W-1:0]] <= hold_q;
                cnt_q <= cnt_q + 1'b1;
            end
            hold_q   <= push_data_i;
            hold_v_q <= 1'b1;
        end
    end

    generate
        for (genvar gi = 0; gi < BLK_WORDS; gi++) begin : g_flat
            assign blk_o[gi*WORD_W +: WORD_W] = store_q[gi];
        end
    endgenerate

    assign cnt_o    = cnt_q;
    assign hold_o   = hold_q;
    assign hold_v_o = hold_v_q;

    assert_push_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && hold_v_q && !clr_i && !load_i && !release_i
        |-> cnt_q < CNT_W'(BLK_WORDS))
        else $error("store overflow");
endmodule

// File: rtl/hash_bit_counter.sv
// Running message length in bits: adds one word width per accepted word.
// The valid-bit correction of the last word is applied by the padder.
module hash_bit_counter #(
    parameter int LEN_W  = hash_seq_pkg::LEN_W,
    parameter int WORD_W = hash_seq_pkg::WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [LEN_W-1:0] bits_o
);
    logic [LEN_W-1:0] bits_q;

    // Count accepted words in units of bits.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) bits_q <= '0;
        else if (inc_i)      bits_q <= bits_q + LEN_W'(WORD_W);
    end

    assign bits_o = bits_q;

    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i && !clr_i |=> bits_o == $past(bits_o) + LEN_W'(WORD_W))
        else $error("bit count step wrong");
    assert_count_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> bits_o == '0)
        else $error("bit count not cleared");
endmodule

// File: rtl/hash_pad_builder.sv
// Combinational padder. From the stored words, the holding word and the
// valid-bit code it forms the first final block, flags whether a second
// block is needed, and forms that second block from latched values.
// Assumes the length field spans the last two words of a block.
module hash_pad_builder #(
    parameter int WORD_W    = hash_seq_pkg::WORD_W,
    parameter int BLK_WORDS = hash_seq_pkg::BLK_WORDS,
    parameter int LEN_W     = hash_seq_pkg::LEN_W,
    localparam int BLK_W    = WORD_W * BLK_WORDS,
    localparam int CNT_W    = $clog2(BLK_WORDS + 1),
    localparam int NB_W     = $clog2(WORD_W),
    localparam int MB_W     = $clog2(BLK_W + 1) + 1
) (
    input  logic [BLK_W-1:0]  words_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [WORD_W-1:0] hold_i,
    input  logic              hold_v_i,
    input  logic [NB_W-1:0]   nb_code_i,
    input  logic [LEN_W-1:0]  bits_i,
    input  logic [LEN_W-1:0]  len2_i,
    input  logic              one2_i,
    output logic [BLK_W-1:0]  blk1_o,
    output logic [BLK_W-1:0]  blk2_o,
    output logic              need2_o,
    output logic              one2_o,
    output logic [LEN_W-1:0]  len_o
);
    logic [NB_W:0]     eff_nb;
    logic [MB_W-1:0]   msg_bits;
    logic [WORD_W-1:0] one_at;
    logic [WORD_W-1:0] keep_mask;

    // Valid bits of the holding word, the one-bit position and derived sizes.
    always_comb begin
        if (!hold_v_i)              eff_nb = '0;
        else if (nb_code_i == '0)   eff_nb = (NB_W+1)'(WORD_W);
        else                        eff_nb = {1'b0, nb_code_i};
        one_at    = (eff_nb < (NB_W+1)'(WORD_W)) ? (WORD_W'(1) << eff_nb) : '0;
        keep_mask = (eff_nb < (NB_W+1)'(WORD_W)) ? (one_at - 1'b1) : '1;
        msg_bits  = MB_W'(cnt_i) * MB_W'(WORD_W) + MB_W'(eff_nb);
        need2_o   = msg_bits > MB_W'(BLK_W - LEN_W - 1);
        one2_o    = msg_bits == MB_W'(BLK_W);
        len_o     = bits_i + LEN_W'(eff_nb) - (hold_v_i ? LEN_W'(WORD_W) : '0);
    end

    generate
        for (genvar gi = 0; gi < BLK_WORDS; gi++) begin : g_word
            logic [WORD_W-1:0] w1;
            logic [WORD_W-1:0] w2;
            // First final block: data, masked last word, one bit, zeros, length.
            always_comb begin
                if (CNT_W'(gi) < cnt_i)
                    w1 = words_i[gi*WORD_W +: WORD_W];
                else if (CNT_W'(gi) == cnt_i)
                    w1 = (hold_i & keep_mask) | one_at;
                else if ((CNT_W+1)'(gi) == {1'b0, cnt_i} + 1'b1)
                    w1 = (eff_nb == (NB_W+1)'(WORD_W)) ? WORD_W'(1) : '0;
                else
                    w1 = '0;
                if (!need2_o && gi == BLK_WORDS - 2) w1 = len_o[WORD_W-1:0];
                if (!need2_o && gi == BLK_WORDS - 1) w1 = len_o[LEN_W-1:WORD_W];
            end
            // Extra block: optional leading one bit, zeros, length.
            always_comb begin
                w2 = '0;
                if (gi == 0)             w2 = one2_i ? WORD_W'(1) : '0;
                if (gi == BLK_WORDS - 2) w2 = len2_i[WORD_W-1:0];
                if (gi == BLK_WORDS - 1) w2 = len2_i[LEN_W-1:WORD_W];
            end
            assign blk1_o[gi*WORD_W +: WORD_W] = w1;
            assign blk2_o[gi*WORD_W +: WORD_W] = w2;
        end
    endgenerate
endmodule

// File: rtl/hash_msg_sequencer.sv
// Top of the hash message input sequencer. Accepts words from a processor
// port or a DMA port, releases full blocks once the next word arrives, and
// on end of message emits one or two padded blocks to the digest core.
// Assumes init_i is asserted before each new message.
module hash_msg_sequencer
    import hash_seq_pkg::*;
#(
    parameter int P_WORD_W    = hash_seq_pkg::WORD_W,
    parameter int P_BLK_WORDS = hash_seq_pkg::BLK_WORDS,
    parameter int P_LEN_W     = hash_seq_pkg::LEN_W,
    localparam int P_BLK_W    = P_WORD_W * P_BLK_WORDS,
    localparam int P_CNT_W    = $clog2(P_BLK_WORDS + 1),
    localparam int P_NB_W     = $clog2(P_WORD_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 init_i,
    input  logic                 cpu_wr_i,
    input  logic [P_WORD_W-1:0]  cpu_wdata_i,
    input  logic                 dma_valid_i,
    input  logic [P_WORD_W-1:0]  dma_wdata_i,
    input  logic                 dma_last_i,
    input  logic                 final_i,
    input  logic [P_NB_W-1:0]    last_bits_i,
    output logic                 in_ready_o,
    output logic                 busy_o,
    output logic                 err_o,
    output logic                 blk_valid_o,
    output logic [P_BLK_W-1:0]   blk_data_o,
    input  logic                 blk_ready_i
);
    seq_state_t          state_q;
    logic                fin_pend_q;
    logic                need2_q;
    logic                one2_q;
    logic [P_LEN_W-1:0]  len_q;
    logic [P_NB_W-1:0]   nb_q;
    logic                err_q;

    logic                wr_any, accept, final_req, pad_go, release_blk, done;
    logic                buf_clr, buf_load;
    logic [P_WORD_W-1:0] wr_data;
    logic [P_BLK_W-1:0]  store_blk, blk1, blk2, load_blk;
    logic [P_CNT_W-1:0]  cnt;
    logic [P_WORD_W-1:0] hold;
    logic                hold_v;
    logic [P_LEN_W-1:0]  bits;
    logic                need2, one2;
    logic [P_LEN_W-1:0]  len_now;

    // Port merge, handshake status and per-cycle control decisions.
    always_comb begin
        wr_data     = dma_valid_i ? dma_wdata_i : cpu_wdata_i;
        wr_any      = cpu_wr_i | dma_valid_i;
        busy_o      = fin_pend_q || state_q == ST_PAD1 || state_q == ST_PAD2;
        in_ready_o  = state_q == ST_FILL && !fin_pend_q;
        blk_valid_o = state_q != ST_FILL;
        accept      = wr_any && in_ready_o && !init_i;
        final_req   = final_i && !busy_o && !init_i;
        pad_go      = state_q == ST_FILL && fin_pend_q && !init_i;
        release_blk = state_q == ST_FULL && blk_ready_i;
        done        = blk_ready_i && ((state_q == ST_PAD1 && !need2_q) || state_q == ST_PAD2);
        buf_clr     = init_i || done;
        buf_load    = pad_go || (state_q == ST_PAD1 && blk_ready_i && need2_q);
        load_blk    = (state_q == ST_PAD1) ? blk2 : blk1;
    end

    hash_word_buffer #(.WORD_W(P_WORD_W), .BLK_WORDS(P_BLK_WORDS)) i_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (buf_clr),
        .push_i     (accept),
        .push_data_i(wr_data),
        .release_i  (release_blk),
        .load_i     (buf_load),
        .load_blk_i (load_blk),
        .blk_o      (store_blk),
        .cnt_o      (cnt),
        .hold_o     (hold),
        .hold_v_o   (hold_v)
    );

    hash_bit_counter #(.LEN_W(P_LEN_W), .WORD_W(P_WORD_W)) i_len (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (buf_clr),
        .inc_i (accept),
        .bits_o(bits)
    );

    hash_pad_builder #(.WORD_W(P_WORD_W), .BLK_WORDS(P_BLK_WORDS), .LEN_W(P_LEN_W)) i_pad (
        .words_i  (store_blk),
        .cnt_i    (cnt),
        .hold_i   (hold),
        .hold_v_i (hold_v),
        .nb_code_i(nb_q),
        .bits_i   (bits),
        .len2_i   (len_q),
        .one2_i   (one2_q),
        .blk1_o   (blk1),
        .blk2_o   (blk2),
        .need2_o  (need2),
        .one2_o   (one2),
        .len_o    (len_now)
    );

    // Sequencer state, end-of-message request and latched padding facts.
    always_ff @(posedge clk) begin
        if (!rst_n || init_i) begin
            state_q    <= ST_FILL;
            fin_pend_q <= 1'b0;
            need2_q    <= 1'b0;
            one2_q     <= 1'b0;
            len_q      <= '0;
            nb_q       <= '0;
        end else begin
            if (final_req || (accept && dma_valid_i && dma_last_i)) begin
                fin_pend_q <= 1'b1;
                nb_q       <= last_bits_i;
            end
            unique case (state_q)
                ST_FILL: begin
                    if (pad_go) begin
                        state_q    <= ST_PAD1;
                        fin_pend_q <= 1'b0;
                        need2_q    <= need2;
                        one2_q     <= one2;
                        len_q      <= len_now;
                    end else if (accept && hold_v && cnt == P_CNT_W'(P_BLK_WORDS - 1)) begin
                        state_q <= ST_FULL;
                    end
                end
                ST_FULL: if (blk_ready_i) state_q <= ST_FILL;
                ST_PAD1: if (blk_ready_i) state_q <= need2_q ? ST_PAD2 : ST_FILL;
                ST_PAD2: if (blk_ready_i) state_q <= ST_FILL;
                default: state_q <= ST_FILL;
            endcase
        end
    end

    // One-cycle error pulse for a data write dropped while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= wr_any && busy_o && !init_i;
    end

    assign err_o      = err_q;
    assign blk_data_o = store_blk;

    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid_o && !blk_ready_i && !init_i |=> blk_valid_o && $stable(blk_data_o))
        else $error("block changed while stalled");
    assert_release_on_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept && hold_v && cnt == P_CNT_W'(P_BLK_WORDS - 1) |=> blk_valid_o && !in_ready_o)
        else $error("full block not presented");
    assert_err_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(busy_o))
        else $error("error pulse without busy");
    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !init_i && !(blk_valid_o && blk_ready_i) |=> busy_o)
        else $error("busy dropped early");
endmodule

// File: tb/test_hash_msg_sequencer.sv
`timescale 1ns/1ps
module test_hash_msg_sequencer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         init_i = 1'b0, cpu_wr_i = 1'b0, dma_valid_i = 1'b0, dma_last_i = 1'b0;
    logic         final_i = 1'b0, blk_ready_i = 1'b1;
    logic [31:0]  cpu_wdata_i = '0, dma_wdata_i = '0;
    logic [4:0]   last_bits_i = '0;
    logic         in_ready_o, busy_o, err_o, blk_valid_o;
    logic [511:0] blk_data_o;

    int n_chk = 0, n_bad = 0, cyc = 0, ncap = 0;
    logic [511:0] cap [8];
    logic [511:0] snap;

    always #4 clk = ~clk;

    hash_msg_sequencer i_hash_msg_sequencer (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .cpu_wr_i(cpu_wr_i),
        .cpu_wdata_i(cpu_wdata_i), .dma_valid_i(dma_valid_i), .dma_wdata_i(dma_wdata_i),
        .dma_last_i(dma_last_i), .final_i(final_i), .last_bits_i(last_bits_i),
        .in_ready_o(in_ready_o), .busy_o(busy_o), .err_o(err_o),
        .blk_valid_o(blk_valid_o), .blk_data_o(blk_data_o), .blk_ready_i(blk_ready_i));

    // Stimulus table: words, valid bits in last word, DMA path, expected block count.
    localparam int NV = 12;
    localparam int VW    [NV] = '{0, 1,  1, 3, 13, 14, 14, 16, 17, 20, 33, 30};
    localparam int VNB   [NV] = '{1, 8, 32, 1, 31, 31, 32, 32,  5, 20, 16, 32};
    localparam int VDMA  [NV] = '{0, 0,  0, 1,  0,  0,  0,  1,  0,  1,  0,  0};
    localparam int VNBLK [NV] = '{1, 1,  1, 1,  1,  1,  2,  2,  2,  2,  3,  3};

    // Record every block at the cycle the core takes it.
    always @(negedge clk) begin
        if (rst_n && blk_valid_o && blk_ready_i) begin
            if (ncap < 8) cap[ncap] = blk_data_o;
            ncap++;
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected below 100000", cyc);
            summary();
        end
    end

    task automatic chk(bit ok, string req, logic [511:0] act, logic [511:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] dword(int m, int i);
        return (32'h9E37_79B9 * 32'(i + 1)) ^ (32'(m) << 24);
    endfunction

    // Padded image of block b built bit by bit from the message length.
    function automatic logic [511:0] exp_block(int m, int w, int nb, int b);
        longint       len;
        int           nblk, g;
        logic [31:0]  wd, msk;
        logic [511:0] r;
        len  = (w == 0) ? 0 : 32 * (w - 1) + nb;
        nblk = int'((len + 64) / 512) + 1;
        msk  = (nb == 32) ? 32'hFFFF_FFFF : ((32'h1 << nb) - 1);
        r    = '0;
        for (int k = 0; k < 16; k++) begin
            g  = b * 16 + k;
            wd = '0;
            if (g < w - 1)       wd = dword(m, g);
            else if (g == w - 1) wd = dword(m, g) & msk;
            if (longint'(g) == len / 32) wd[int'(len % 32)] = 1'b1;
            if (b == nblk - 1 && k == 14) wd = len[31:0];
            if (b == nblk - 1 && k == 15) wd = len[63:32];
            r[k*32 +: 32] = wd;
        end
        return r;
    endfunction

    task automatic pulse_init();
        @(posedge clk); #1 init_i = 1'b1;
        @(posedge clk); #1 init_i = 1'b0;
    endtask

    task automatic put_word(logic [31:0] d, bit dma, bit last, logic [4:0] code);
        while (!in_ready_o) begin @(posedge clk); #1; end
        if (dma) begin dma_valid_i = 1'b1; dma_wdata_i = d; dma_last_i = last; end
        else begin cpu_wr_i = 1'b1; cpu_wdata_i = d; end
        last_bits_i = code;
        @(posedge clk); #1;
        dma_valid_i = 1'b0; dma_last_i = 1'b0; cpu_wr_i = 1'b0;
    endtask

    task automatic raw_write(logic [31:0] d);
        cpu_wr_i = 1'b1; cpu_wdata_i = d;
        @(posedge clk); #1 cpu_wr_i = 1'b0;
    endtask

    task automatic pulse_final(logic [4:0] code);
        final_i = 1'b1; last_bits_i = code;
        @(posedge clk); #1 final_i = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (busy_o || blk_valid_o) @(negedge clk);
        @(posedge clk); #1;
    endtask

    function automatic logic [4:0] code_of(int nb);
        return (nb == 32) ? 5'd0 : 5'(nb);
    endfunction

    initial begin
        string tag;
        int    lbits;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready_o == 1'b1, "R1 in_ready", 512'(in_ready_o), 512'(1));
        chk(busy_o == 1'b0, "R1 busy", 512'(busy_o), 512'(0));
        chk(blk_valid_o == 1'b0, "R1 blk_valid", 512'(blk_valid_o), 512'(0));
        chk(err_o == 1'b0, "R1 err", 512'(err_o), 512'(0));

        // Table walk: R2 full blocks, R5 final block, R6 extra block, R7 DMA end, R10 empty.
        for (int v = 0; v < NV; v++) begin
            @(posedge clk); #1;
            pulse_init();
            ncap = 0;
            for (int i = 0; i < VW[v]; i++)
                put_word(dword(v, i), VDMA[v] != 0, (VDMA[v] != 0) && (i == VW[v] - 1), code_of(VNB[v]));
            if (VDMA[v] == 0) pulse_final(code_of(VNB[v]));
            wait_idle();
            tag = (VW[v] == 0) ? "R10 count" : ((VDMA[v] != 0) ? "R7 count" : "R6 count");
            chk(ncap == VNBLK[v], tag, 512'(ncap), 512'(VNBLK[v]));
            lbits = (VW[v] == 0) ? 0 : 32 * (VW[v] - 1) + VNB[v];
            for (int b = 0; b < VNBLK[v] && b < 8; b++) begin
                if (VW[v] == 0)                                 tag = "R10 block";
                else if (b == VNBLK[v] - 1)                     tag = "R5 block";
                else if (b == VNBLK[v] - 2 && (lbits % 512) > 447) tag = "R6 block";
                else                                            tag = "R2 block";
                chk(cap[b] == exp_block(v, VW[v], VNB[v], b), tag, cap[b], exp_block(v, VW[v], VNB[v], b));
            end
            chk(busy_o == 1'b0, "R8 busy cleared", 512'(busy_o), 512'(0));
        end

        // R3 / R4: core stalled on a released full block.
        pulse_init();
        ncap = 0;
        blk_ready_i = 1'b0;
        for (int i = 0; i < 17; i++) put_word(dword(20, i), 1'b0, 1'b0, 5'd0);
        @(negedge clk);
        chk(blk_valid_o == 1'b1, "R2 release on 17th", 512'(blk_valid_o), 512'(1));
        chk(in_ready_o == 1'b0, "R3 not ready", 512'(in_ready_o), 512'(0));
        snap = blk_data_o;
        @(posedge clk); #1;
        raw_write(32'hDEAD_BEEF);
        @(negedge clk);
        chk(err_o == 1'b0, "R3 no error on full", 512'(err_o), 512'(0));
        repeat (3) @(negedge clk);
        chk(blk_data_o == snap && blk_valid_o, "R4 stable", blk_data_o, snap);
        chk(snap == exp_block(20, 17, 32, 0), "R2 first block", snap, exp_block(20, 17, 32, 0));
        @(posedge clk); #1 blk_ready_i = 1'b1;
        pulse_final(5'd0);
        wait_idle();
        chk(ncap == 2, "R3 count", 512'(ncap), 512'(2));
        chk(cap[1] == exp_block(20, 17, 32, 1), "R3 dropped word", cap[1], exp_block(20, 17, 32, 1));

        // R8: writes during busy are dropped and flagged.
        pulse_init();
        ncap = 0;
        blk_ready_i = 1'b0;
        for (int i = 0; i < 2; i++) put_word(dword(21, i), 1'b0, 1'b0, 5'd12);
        pulse_final(5'd12);
        @(negedge clk);
        chk(busy_o == 1'b1, "R8 busy", 512'(busy_o), 512'(1));
        @(posedge clk); #1;
        raw_write(32'h1234_5678);
        @(negedge clk);
        chk(err_o == 1'b1, "R8 err pulse", 512'(err_o), 512'(1));
        @(negedge clk);
        chk(err_o == 1'b0, "R8 err one cycle", 512'(err_o), 512'(0));
        chk(busy_o == 1'b1, "R8 busy held", 512'(busy_o), 512'(1));
        @(posedge clk); #1 blk_ready_i = 1'b1;
        wait_idle();
        chk(ncap == 1 && cap[0] == exp_block(21, 2, 12, 0), "R8 write ignored", cap[0], exp_block(21, 2, 12, 0));
        chk(busy_o == 1'b0, "R8 busy end", 512'(busy_o), 512'(0));

        // R9: init mid-message discards words and length.
        pulse_init();
        for (int i = 0; i < 5; i++) put_word(dword(22, i), 1'b0, 1'b0, 5'd0);
        pulse_init();
        ncap = 0;
        for (int i = 0; i < 2; i++) put_word(dword(23, i), 1'b0, 1'b0, 5'd16);
        pulse_final(5'd16);
        wait_idle();
        chk(ncap == 1 && cap[0] == exp_block(23, 2, 16, 0), "R9 restart", cap[0], exp_block(23, 2, 16, 0));

        summary();
    end
endmodule